// File: doc/BRIEF.md
# Reaction Timer Game Controller

This block runs a reaction-time game. A player turns on an enable switch, then presses and releases a start button. After a delay of a random whole number of seconds, one of ten LEDs lights. The player must then turn on the stop switch that sits under that LED. The block counts the elapsed time in milliseconds as a four-digit BCD value while it waits. When the matching switch turns on, the block freezes the count and shows it. It also keeps the lowest time seen so far as the best score.

A random source outside the block supplies the delay in seconds and the LED index. The delay value is sampled when the button is released. The LED index is sampled when the delay runs out. The block has a single system clock. Two prescalers on that clock produce one-cycle millisecond and second enables. Seven-segment encoding is left to a downstream decoder, which is told through `disp_on` whether the digits should be blank.

Top module: `rxn_timer_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in the show-best state. `disp_on` is 1, `disp_bcd` reads 16'h9999, and `led` is all zero.
- R2: With `enable_sw` high in the show-best state, the next clock edge enters idle. In idle, `disp_on` is 0, `disp_bcd` is 0 and `led` is 0.
- R3: Whenever `enable_sw` is sampled low, the next clock edge enters the show-best state from any state. `led` then reads 0 and `disp_bcd` shows the best score.
- R4: A press of `start_btn` (active high) has no effect until the button is released. Edge 1 is the first rising edge that samples the released level. The chosen LED turns on after edge 4 + N·CLKS_PER_MS·MS_PER_SEC, where N is `rnd_secs`. During the delay, `disp_on` and `led` stay 0.
- R5: During the delay, a start-button release or a 0-to-1 change on any stop switch cancels the delay and returns to idle. No LED lights, and a later start begins a fresh delay.
- R6: `led` is one-hot at bit k while timing. k is `rnd_led`, sampled when the delay ends. Any index of NUM_LEDS or above lights bit NUM_LEDS-1.
- R7: While timing, `disp_on` is 1. `disp_bcd` holds floor(c / CLKS_PER_MS), where c is the number of clock edges since the LED lit. `disp_bcd` uses 4-bit BCD digits, with the units digit in bits [3:0] and thousands in bits [15:12].
- R8: The millisecond count stops at 9999 and holds there.
- R9: Only a 0-to-1 change on the stop switch under the lit LED ends timing. Other switches are ignored and the LED stays lit. After the stop, `led` is 0 and `disp_bcd` holds the final count.
- R10: After a stop, the best score takes the final count only if that count is lower. Otherwise the best score is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_sw | input | 1 | Game enable switch |
| start_btn | input | 1 | Start button, high while pressed |
| stop_sw | input | NUM_LEDS | Stop switches, one under each LED |
| rnd_secs | input | DELAY_W | Random delay in seconds |
| rnd_led | input | IDX_W | Random LED index |
| led | output | NUM_LEDS | One-hot LED drive |
| disp_on | output | 1 | Digits should be shown (0 means blank) |
| disp_bcd | output | 16 | Four BCD digits, units in [3:0] |

## Verification
The assertions assume that the stop switches and the enable switch are already synchronous to `clk`, since only the start button passes through a synchronizer. They also assume that reset is held for at least two edges. The bench drives every input on the falling clock edge, holds reset for several cycles, and returns all stop switches to zero between rounds. It keeps `rnd_secs` and `rnd_led` steady for the whole round, so the sampled values are known. Indices above the LED count are swept on purpose, to exercise the clamp.

// File: rtl/rxn_pkg.sv
package rxn_pkg;

    localparam int BCD_DIGITS = 4;

    typedef logic [4*BCD_DIGITS-1:0] bcd_word_t;

    localparam bcd_word_t BCD_MAX = {BCD_DIGITS{4'd9}};

    typedef enum logic [2:0] {
        ST_BEST  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_RUN   = 3'd3,
        ST_SCORE = 3'd4
    } rxn_state_e;

    // true when every nibble holds a legal decimal digit
    function automatic logic bcd_ok(bcd_word_t w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < BCD_DIGITS; i++) begin
            if (w[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/rxn_tick_gen.sv
module rxn_tick_gen #(
    parameter int CLKS_PER_MS = 50000,
    parameter int MS_PER_SEC  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic ms_tick,
    output logic sec_tick
);
    localparam int MS_W  = $clog2(CLKS_PER_MS + 1);
    localparam int SEC_W = $clog2(MS_PER_SEC + 1);

    logic [MS_W-1:0]  ms_cnt;
    logic [SEC_W-1:0] sec_cnt;

    assign ms_tick  = (ms_cnt == MS_W'(CLKS_PER_MS - 1));
    assign sec_tick = ms_tick && (sec_cnt == SEC_W'(MS_PER_SEC - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ms_cnt  <= '0;
            sec_cnt <= '0;
        end else begin
            ms_cnt <= ms_tick ? '0 : ms_cnt + MS_W'(1);
            if (ms_tick) begin
                sec_cnt <= sec_tick ? '0 : sec_cnt + SEC_W'(1);
            end
        end
    end
endmodule

// File: rtl/rxn_btn_event.sv
module rxn_btn_event (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic release_ev
);
    logic sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= btn;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign release_ev = prev_q && !sync2_q;
endmodule

// File: rtl/rxn_bcd_count.sv
module rxn_bcd_count
    import rxn_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      inc,
    output bcd_word_t value
);
    logic [3:0]            dig [BCD_DIGITS];
    logic [BCD_DIGITS-1:0] carry;
    logic                  full;

    assign full     = (value == BCD_MAX);
    assign carry[0] = inc && !full;

    for (genvar i = 0; i < BCD_DIGITS; i++) begin : g_digit
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                dig[i] <= 4'd0;
            end else if (carry[i]) begin
                dig[i] <= (dig[i] == 4'd9) ? 4'd0 : dig[i] + 4'd1;
            end
        end
        assign value[4*i +: 4] = dig[i];
        if (i < BCD_DIGITS - 1) begin : g_carry
            assign carry[i+1] = carry[i] && (dig[i] == 4'd9);
        end
    end
endmodule

// File: rtl/rxn_timer_ctrl.sv
module rxn_timer_ctrl
    import rxn_pkg::*;
#(
    parameter int CLKS_PER_MS = 50000,
    parameter int MS_PER_SEC  = 1000,
    parameter int NUM_LEDS    = 10,
    parameter int DELAY_W     = 3,
    parameter int IDX_W       = $clog2(NUM_LEDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable_sw,
    input  logic                    start_btn,
    input  logic [NUM_LEDS-1:0]     stop_sw,
    input  logic [DELAY_W-1:0]      rnd_secs,
    input  logic [IDX_W-1:0]        rnd_led,
    output logic [NUM_LEDS-1:0]     led,
    output logic                    disp_on,
    output logic [4*BCD_DIGITS-1:0] disp_bcd
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_LEDS - 1);

    rxn_state_e          state_q, state_d;
    logic                start_ev, ms_tick, sec_tick, tick_clr;
    logic                cnt_clr, cnt_inc, hit, abort_wait;
    logic [NUM_LEDS-1:0] stop_prev_q, stop_rise, lit_mask;
    logic [IDX_W-1:0]    lit_idx_q, idx_pick;
    logic [DELAY_W-1:0]  dly_q;
    bcd_word_t           run_cnt, best_q;

    rxn_btn_event u_btn (
        .clk        (clk),
        .rst        (rst),
        .btn        (start_btn),
        .release_ev (start_ev)
    );

    rxn_tick_gen #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .MS_PER_SEC  (MS_PER_SEC)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .clr      (tick_clr),
        .ms_tick  (ms_tick),
        .sec_tick (sec_tick)
    );

    rxn_bcd_count u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .value (run_cnt)
    );

    // stop switch edges and lit-LED decode
    assign stop_rise = stop_sw & ~stop_prev_q;
    assign idx_pick  = (rnd_led > TOP_IDX) ? TOP_IDX : rnd_led;

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_dec
        assign lit_mask[i] = (lit_idx_q == IDX_W'(i));
    end

    assign hit        = |(stop_rise & lit_mask);
    assign abort_wait = start_ev || (|stop_rise);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable_sw) begin
            state_d = ST_BEST;
        end else begin
            case (state_q)
                ST_BEST:  state_d = ST_IDLE;
                ST_IDLE:  if (start_ev) state_d = ST_WAIT;
                ST_WAIT: begin
                    if (abort_wait)         state_d = ST_IDLE;
                    else if (dly_q == '0)   state_d = ST_RUN;
                end
                ST_RUN:   if (hit) state_d = ST_SCORE;
                ST_SCORE: state_d = ST_SCORE;
                default:  state_d = ST_BEST;
            endcase
        end
    end

    assign tick_clr = (state_d != state_q) && (state_d == ST_WAIT || state_d == ST_RUN);
    assign cnt_clr  = (state_q == ST_WAIT) && (state_d == ST_RUN);
    assign cnt_inc  = (state_q == ST_RUN) && ms_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_BEST;
            stop_prev_q <= '0;
            lit_idx_q   <= '0;
            dly_q       <= '0;
            best_q      <= BCD_MAX;
        end else begin
            state_q     <= state_d;
            stop_prev_q <= stop_sw;
            if (state_q == ST_IDLE && state_d == ST_WAIT) begin
                dly_q <= rnd_secs;
            end else if (state_q == ST_WAIT && sec_tick && dly_q != '0) begin
                dly_q <= dly_q - DELAY_W'(1);
            end
            if (cnt_clr) begin
                lit_idx_q <= idx_pick;
            end
            if (state_q == ST_SCORE && run_cnt < best_q) begin
                best_q <= run_cnt;
            end
        end
    end

    // outputs
    assign led     = (state_q == ST_RUN) ? lit_mask : '0;
    assign disp_on = (state_q == ST_BEST) || (state_q == ST_RUN) || (state_q == ST_SCORE);

    always_comb begin
        if (state_q == ST_BEST)  disp_bcd = best_q;
        else if (disp_on)        disp_bcd = run_cnt;
        else                     disp_bcd = '0;
    end
endmodule

// File: rtl/rxn_timer_chk.sv
module rxn_timer_chk
    import rxn_pkg::*;
#(
    parameter int NUM_LEDS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                enable_sw,
    input rxn_state_e          state_q,
    input logic [NUM_LEDS-1:0] led,
    input logic                hit,
    input logic                ms_tick,
    input bcd_word_t           run_cnt,
    input bcd_word_t           best_q
);
    // R6
    led_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(led));

    // R3
    enable_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !enable_sw |=> (state_q == ST_BEST));

    // R8
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        bcd_ok(run_cnt));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !ms_tick) |=> $stable(run_cnt));

    // R9
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && enable_sw && !hit) |=> (state_q == ST_RUN));

    // R10
    best_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_SCORE) |=> $stable(best_q));

    // R10
    best_never_up_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCORE) |=> (best_q <= $past(best_q)));
endmodule

bind rxn_timer_ctrl rxn_timer_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable_sw (enable_sw),
    .state_q   (state_q),
    .led       (led),
    .hit       (hit),
    .ms_tick   (ms_tick),
    .run_cnt   (run_cnt),
    .best_q    (best_q)
);

// File: tb/sim_rxn_timer_ctrl.sv
`timescale 1ns/100ps
module sim_rxn_timer_ctrl;
    localparam int CPM  = 3;
    localparam int MPS  = 4;
    localparam int NL   = 10;
    localparam int SECP = CPM * MPS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_sw = 1'b0;
    logic        start_btn = 1'b0;
    logic [9:0]  stop_sw = '0;
    logic [2:0]  rnd_secs = '0;
    logic [3:0]  rnd_led = '0;
    logic [9:0]  led;
    logic        disp_on;
    logic [15:0] disp_bcd;

    int errs = 0;
    int checks = 0;
    int exp_best = 9999;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxn_timer_ctrl #(
        .CLKS_PER_MS (CPM),
        .MS_PER_SEC  (MPS),
        .NUM_LEDS    (NL),
        .DELAY_W     (3)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .enable_sw (enable_sw),
        .start_btn (start_btn),
        .stop_sw   (stop_sw),
        .rnd_secs  (rnd_secs),
        .rnd_led   (rnd_led),
        .led       (led),
        .disp_on   (disp_on),
        .disp_bcd  (disp_bcd)
    );

    function automatic logic [15:0] to_bcd(int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic press_release();
        start_btn = 1'b1;
        repeat (3) @(negedge clk);
        start_btn = 1'b0;
    endtask

    // edges until an LED shows, counting the first sampling edge as 1
    task automatic wait_led(output int cyc, input int limit);
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (led == '0 && cyc < limit);
    endtask

    task automatic play_round(input int n, input int idx, input int extra);
        int cyc, w, lit, wrong, score;
        enable_sw = 1'b1;
        rnd_secs  = 3'(n);
        rnd_led   = 4'(idx);
        @(negedge clk);
        chk(!disp_on && led == '0 && disp_bcd == '0, "R2 idle dark", {disp_on, led}, 0);
        press_release();
        wait_led(cyc, 200);
        chk(cyc == n * SECP + 4, "R4 delay", cyc, n * SECP + 4);
        lit = (idx > NL - 1) ? NL - 1 : idx;
        chk(led == 10'(1 << lit), "R6 decode", led, 1 << lit);
        w = 0;
        wrong = (lit + 1) % NL;
        stop_sw[wrong] = 1'b1;
        repeat (2) begin @(negedge clk); w++; end
        chk(led == 10'(1 << lit), "R9 wrong switch", led, 1 << lit);
        repeat (extra) begin @(negedge clk); w++; end
        chk(disp_on && disp_bcd == to_bcd((w / CPM > 9999) ? 9999 : w / CPM),
            "R7 R8 running count", disp_bcd, to_bcd((w / CPM > 9999) ? 9999 : w / CPM));
        stop_sw[lit] = 1'b1;
        score = ((w + 1) / CPM > 9999) ? 9999 : (w + 1) / CPM;
        repeat (2) @(negedge clk);
        chk(disp_bcd == to_bcd(score) && led == '0, "R9 final score", disp_bcd, to_bcd(score));
        if (score < exp_best) exp_best = score;
        enable_sw = 1'b0;
        @(negedge clk);
        chk(disp_on && disp_bcd == to_bcd(exp_best), "R10 best", disp_bcd, to_bcd(exp_best));
        stop_sw = '0;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
        end
    endtask

    initial begin
        int cyc;
        repeat (5) @(negedge clk);
        chk(disp_on && disp_bcd == 16'h9999 && led == '0, "R1 in reset", disp_bcd, 16'h9999);
        rst = 1'b0;
        @(negedge clk);
        chk(disp_on && disp_bcd == 16'h9999 && led == '0, "R1 after reset", disp_bcd, 16'h9999);

        // sweep delays 0..7 and indices 0..15 (clamp above 9)
        for (int r = 0; r < 16; r++) begin
            play_round(r % 8, r, (r * 37) % 50 + 1);
        end

        // R8 saturation; 9999 is not lower than the best, so R10 keeps it
        play_round(0, 3, 30010);

        // R5 abort by stop switch during delay
        enable_sw = 1'b1; rnd_secs = 3'd5; rnd_led = 4'd4;
        @(negedge clk);
        press_release();
        repeat (10) @(negedge clk);
        stop_sw[6] = 1'b1;
        repeat (5 * SECP + 10) @(negedge clk);
        chk(led == '0 && !disp_on, "R5 stop abort", led, 0);
        stop_sw = '0;
        rnd_secs = 3'd0;
        @(negedge clk);
        press_release();
        wait_led(cyc, 200);
        chk(cyc == 4, "R5 restart after abort", cyc, 4);

        // R3 enable drop while timing
        enable_sw = 1'b0;
        @(negedge clk);
        chk(led == '0 && disp_on && disp_bcd == to_bcd(exp_best), "R3 drop in run", disp_bcd, to_bcd(exp_best));

        // R5 abort by second start release during delay
        enable_sw = 1'b1; rnd_secs = 3'd4;
        @(negedge clk);
        press_release();
        repeat (8) @(negedge clk);
        press_release();
        repeat (4 * SECP + 10) @(negedge clk);
        chk(led == '0 && !disp_on, "R5 start abort", led, 0);

        // R3 enable drop while idle / delay
        press_release();
        repeat (6) @(negedge clk);
        enable_sw = 1'b0;
        @(negedge clk);
        chk(disp_on && disp_bcd == to_bcd(exp_best), "R3 drop in delay", disp_bcd, to_bcd(exp_best));
        repeat (5 * SECP) @(negedge clk);
        chk(led == '0, "R3 stays in show-best", led, 0);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end
endmodule